// File: doc/BRIEF.md
# Debug Byte-Stream Command Executor

This block sits behind a debug physical layer that has already turned the serial line into whole bytes. It reads a command byte, optionally gathers address and data bytes, and then carries out the command as a series of single-byte transfers. Targets are a byte-wide data-space bus, a 32-bit pointer register, and a small bank of control/status bytes. Bytes read from any target leave as an outgoing byte stream that the physical layer serializes.

Three streams use valid/ready. A byte moves when both valid and ready are high at a rising clock edge. On the incoming byte stream the executor raises `rx_ready` only while it waits for a command, address or write-data byte. It holds `rx_ready` low while a bus access or an outgoing byte is pending, which pushes back on the physical layer. On the outgoing stream `tx_valid` and `tx_data` stay fixed until `tx_ready` is seen. On the data-space bus `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` stay fixed until `bus_ready` is seen, and read data is taken from `bus_rdata` in the cycle `bus_ready` is high.

The command byte has three fields. Bits [7:5] hold the opcode, bits [3:2] hold an address-size or indirect-mode field, and bits [1:0] hold a data-size field. Every size field is coded as byte count minus one. All multi-byte values travel least significant byte first.

Top module: `dbgx_exec`

## Requirements
- R1: During and after reset, `rx_ready` is 1, `tx_valid` and `bus_valid` are 0, every control/status byte is 0, and the pointer reads back as 0.
- R2: Opcode values in bits [7:5] are: 0 direct load, 1 direct store, 2 indirect load, 3 indirect store, 4 status load, 5 status store. Opcodes 6 and 7 consume only the command byte, cause no bus or outgoing traffic, and leave the executor ready for a new command.
- R3: A direct store first takes (bits[3:2]+1) address bytes, LSB first. It then takes (bits[1:0]+1) data bytes. After byte n arrives, it performs one bus write of that byte at base+n.
- R4: A direct load takes its address bytes in the same way, then performs (bits[1:0]+1) bus reads at base+n. Each byte read is sent on the outgoing stream, and the next read starts only after that byte has been accepted.
- R5: Indirect mode 1 (bits[3:2]=01) accesses data at pointer+n for byte n and leaves the pointer unchanged.
- R6: Indirect mode 2 (bits[3:2]=10) accesses data at pointer+n and adds one to the pointer for every completed byte access.
- R7: Indirect modes 0 and 3 access the pointer register itself, with no bus traffic. A load returns its bytes LSB first. A store replaces byte n with data byte n and leaves higher bytes that were not sent unchanged.
- R8: A status command takes the register index from bits [3:0] and moves exactly one byte with no bus traffic. An index at or above the bank size reads as 0, and a write to it changes nothing.
- R9: Bus requests and outgoing bytes are held stable until accepted, and `rx_ready` is low whenever `bus_valid` or `tx_valid` is high.
- R10: The bus address is the low ADDR_W bits of the 32-bit sum base+n, so it wraps at the top of the bus address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Incoming byte available |
| rx_ready | output | 1 | Executor accepts an incoming byte |
| rx_data | input | 8 | Incoming byte |
| tx_valid | output | 1 | Outgoing byte available |
| tx_ready | input | 1 | Physical layer accepts the outgoing byte |
| tx_data | output | 8 | Outgoing byte |
| bus_valid | output | 1 | Data-space bus request |
| bus_ready | input | 1 | Bus completes the request this cycle |
| bus_write | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Byte address |
| bus_wdata | output | 8 | Write byte |
| bus_rdata | input | 8 | Read byte, valid with bus_ready |
| csr_regs | output | 8*NUM_CSR | Control/status bytes, index k at bits [8k+7:8k] |

## Verification
The bench builds the block with ADDR_W=16 and NUM_CSR=4. The narrow bus address lets a four-byte direct address reach the point where base+n wraps from 0xFFFF to 0x0000. The four-entry bank makes status index 6 an out-of-range access, so both the zero read and the write that changes nothing can be observed. Stalling patterns on `bus_ready` and `tx_ready` test that requests stay stable and that the incoming stream is held back.

// File: rtl/dbgx_pkg.sv
package dbgx_pkg;

  localparam int PTR_W = 32;

  localparam logic [2:0] OP_LD_DIR = 3'd0;
  localparam logic [2:0] OP_ST_DIR = 3'd1;
  localparam logic [2:0] OP_LD_IND = 3'd2;
  localparam logic [2:0] OP_ST_IND = 3'd3;
  localparam logic [2:0] OP_LD_CSR = 3'd4;
  localparam logic [2:0] OP_ST_CSR = 3'd5;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_BUS  = 2'd1,
    TGT_PTR  = 2'd2,
    TGT_CSR  = 2'd3
  } tgt_e;

  typedef struct packed {
    logic       legal;
    logic       is_load;
    logic       need_addr;
    logic       post_inc;
    tgt_e       tgt;
    logic [1:0] alast;
    logic [1:0] dlast;
    logic [3:0] csr_idx;
  } cmd_t;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_ADDR = 3'd1,
    S_RXD  = 3'd2,
    S_WR   = 3'd3,
    S_RD   = 3'd4,
    S_TX   = 3'd5
  } state_e;

endpackage

// File: rtl/dbgx_decode.sv
module dbgx_decode
  import dbgx_pkg::*;
(
  input  logic [7:0] cmd,
  output cmd_t       dec
);
  logic [2:0] op;
  logic [1:0] mode;

  assign op   = cmd[7:5];
  assign mode = cmd[3:2];

  always_comb begin
    dec           = '0;
    dec.tgt       = TGT_NONE;
    dec.csr_idx   = cmd[3:0];
    case (op)
      OP_LD_DIR, OP_ST_DIR: begin
        dec.legal     = 1'b1;
        dec.is_load   = (op == OP_LD_DIR);
        dec.need_addr = 1'b1;
        dec.tgt       = TGT_BUS;
        dec.alast     = cmd[3:2];
        dec.dlast     = cmd[1:0];
      end
      OP_LD_IND, OP_ST_IND: begin
        dec.legal    = 1'b1;
        dec.is_load  = (op == OP_LD_IND);
        dec.dlast    = cmd[1:0];
        dec.post_inc = (mode == 2'b10);
        dec.tgt      = (mode == 2'b01 || mode == 2'b10) ? TGT_BUS : TGT_PTR;
      end
      OP_LD_CSR, OP_ST_CSR: begin
        dec.legal   = 1'b1;
        dec.is_load = (op == OP_LD_CSR);
        dec.tgt     = TGT_CSR;
        dec.dlast   = 2'd0;
      end
      default: dec.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/dbgx_ptr.sv
module dbgx_ptr
  import dbgx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_idx,
  input  logic [7:0]       wr_byte,
  input  logic             inc_en,
  output logic [PTR_W-1:0] ptr_q
);
  localparam int NBYTES = PTR_W / 8;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ptr_q[8*b +: 8] <= 8'h00;
      end else if (wr_en && (wr_idx == 2'(b))) begin
        ptr_q[8*b +: 8] <= wr_byte;
      end else if (inc_en) begin
        ptr_q[8*b +: 8] <= 8'(({{(PTR_W-1){1'b0}}, 1'b1} + ptr_q) >> (8*b));
      end
    end
  end
endmodule

// File: rtl/dbgx_csr.sv
module dbgx_csr #(
  parameter int NUM_CSR = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [3:0]           idx,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  output logic [8*NUM_CSR-1:0] regs_flat
);
  logic [7:0] regs [NUM_CSR];

  for (genvar g = 0; g < NUM_CSR; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                         regs[g] <= 8'h00;
      else if (wr_en && idx == 4'(g))     regs[g] <= wdata;
    end
    assign regs_flat[8*g +: 8] = regs[g];
  end

  always_comb begin
    rdata = 8'h00;
    for (int k = 0; k < NUM_CSR; k++) begin
      if (idx == 4'(k)) rdata = regs[k];
    end
  end
endmodule

// File: rtl/dbgx_exec.sv
module dbgx_exec
  import dbgx_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int NUM_CSR = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_valid,
  output logic                 rx_ready,
  input  logic [7:0]           rx_data,
  output logic                 tx_valid,
  input  logic                 tx_ready,
  output logic [7:0]           tx_data,
  output logic                 bus_valid,
  input  logic                 bus_ready,
  output logic                 bus_write,
  output logic [ADDR_W-1:0]    bus_addr,
  output logic [7:0]           bus_wdata,
  input  logic [7:0]           bus_rdata,
  output logic [8*NUM_CSR-1:0] csr_regs
);
  state_e           state_q;
  cmd_t             cmd_q;
  cmd_t             dec;
  logic [1:0]       idx_q;
  logic [PTR_W-1:0] base_q;
  logic [7:0]       dbyte_q;
  logic [PTR_W-1:0] ptr_q;
  logic [7:0]       csr_rdata;
  logic [7:0]       src_byte;
  logic             rx_fire, step_done, last_byte;
  logic             ptr_wr, ptr_inc, csr_wr;

  dbgx_decode u_dec (.cmd(rx_data), .dec(dec));

  dbgx_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_en(ptr_wr), .wr_idx(idx_q),
    .wr_byte(dbyte_q), .inc_en(ptr_inc), .ptr_q(ptr_q)
  );

  dbgx_csr #(.NUM_CSR(NUM_CSR)) u_csr (
    .clk(clk), .rst_n(rst_n), .wr_en(csr_wr), .idx(cmd_q.csr_idx),
    .wdata(dbyte_q), .rdata(csr_rdata), .regs_flat(csr_regs)
  );

  assign rx_ready  = (state_q == S_IDLE) || (state_q == S_ADDR) || (state_q == S_RXD);
  assign rx_fire   = rx_valid && rx_ready;
  assign bus_valid = ((state_q == S_WR) || (state_q == S_RD)) && (cmd_q.tgt == TGT_BUS);
  assign bus_write = (state_q == S_WR);
  assign bus_addr  = ADDR_W'(base_q + PTR_W'(idx_q));
  assign bus_wdata = dbyte_q;
  assign tx_valid  = (state_q == S_TX);
  assign tx_data   = dbyte_q;
  assign step_done = ((state_q == S_WR) || (state_q == S_RD)) &&
                     ((cmd_q.tgt != TGT_BUS) || bus_ready);
  assign last_byte = (idx_q == cmd_q.dlast);
  assign ptr_wr    = (state_q == S_WR) && (cmd_q.tgt == TGT_PTR);
  assign csr_wr    = (state_q == S_WR) && (cmd_q.tgt == TGT_CSR);
  assign ptr_inc   = bus_valid && bus_ready && cmd_q.post_inc;

  always_comb begin
    case (cmd_q.tgt)
      TGT_BUS: src_byte = bus_rdata;
      TGT_PTR: src_byte = ptr_q[8*idx_q +: 8];
      TGT_CSR: src_byte = csr_rdata;
      default: src_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cmd_q   <= '0;
      idx_q   <= 2'd0;
      base_q  <= '0;
      dbyte_q <= 8'h00;
    end else begin
      case (state_q)
        S_IDLE: if (rx_fire) begin
          cmd_q  <= dec;
          idx_q  <= 2'd0;
          base_q <= dec.need_addr ? '0 : ptr_q;
          if (!dec.legal)        state_q <= S_IDLE;
          else if (dec.need_addr) state_q <= S_ADDR;
          else if (dec.is_load)  state_q <= S_RD;
          else                   state_q <= S_RXD;
        end
        S_ADDR: if (rx_fire) begin
          base_q[8*idx_q +: 8] <= rx_data;
          if (idx_q == cmd_q.alast) begin
            idx_q   <= 2'd0;
            state_q <= cmd_q.is_load ? S_RD : S_RXD;
          end else begin
            idx_q <= idx_q + 2'd1;
          end
        end
        S_RXD: if (rx_fire) begin
          dbyte_q <= rx_data;
          state_q <= S_WR;
        end
        S_WR: if (step_done) begin
          if (last_byte) begin
            state_q <= S_IDLE;
          end else begin
            idx_q   <= idx_q + 2'd1;
            state_q <= S_RXD;
          end
        end
        S_RD: if (step_done) begin
          dbyte_q <= src_byte;
          state_q <= S_TX;
        end
        S_TX: if (tx_ready) begin
          if (last_byte) begin
            state_q <= S_IDLE;
          end else begin
            idx_q   <= idx_q + 2'd1;
            state_q <= S_RD;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R9
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) &&
                                   $stable(bus_write) && $stable(bus_wdata)));
  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R9
  rx_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid || tx_valid) |-> !rx_ready);
  // R6
  ptr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && cmd_q.post_inc) |=> (ptr_q == $past(ptr_q) + 32'd1));
  // R5
  ptr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && !cmd_q.post_inc) |=> $stable(ptr_q));
  // R8
  csr_nobus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != S_IDLE) && (cmd_q.tgt == TGT_CSR)) |-> !bus_valid);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (rx_ready && !tx_valid && !bus_valid));

endmodule

// File: tb/tb_dbgx_exec.sv
module tb_dbgx_exec;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int NUM_CSR    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_ready;
  logic [7:0] rx_data = 8'h00;
  logic tx_valid, tx_ready = 1'b1;
  logic [7:0] tx_data;
  logic bus_valid, bus_ready = 1'b1, bus_write;
  logic [ADDR_W-1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [8*NUM_CSR-1:0] csr_regs;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit bus_stall = 0, tx_stall = 0;
  logic [31:0] wr_addr [64];
  logic [7:0]  wr_data [64];
  logic [31:0] rd_addr [64];
  logic [7:0]  tx_b    [64];
  int wr_n = 0, rd_n = 0, tx_n = 0, overlap_n = 0;

  dbgx_exec #(.ADDR_W(ADDR_W), .NUM_CSR(NUM_CSR)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .csr_regs(csr_regs)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign bus_rdata = mem_f(bus_addr);

  always @(posedge clk) begin
    cyc = cyc + 1;
    #1;
    bus_ready = bus_stall ? (cyc % 3 == 0) : 1'b1;
    tx_ready  = tx_stall  ? (cyc % 2 == 0) : 1'b1;
  end

  always @(negedge clk) if (rst_n) begin
    if (bus_valid && bus_ready) begin
      if (bus_write && wr_n < 64) begin
        wr_addr[wr_n] = 32'(bus_addr); wr_data[wr_n] = bus_wdata; wr_n++;
      end else if (!bus_write && rd_n < 64) begin
        rd_addr[rd_n] = 32'(bus_addr); rd_n++;
      end
    end
    if (tx_valid && tx_ready && tx_n < 64) begin
      tx_b[tx_n] = tx_data; tx_n++;
    end
    if ((bus_valid || tx_valid) && rx_ready) overlap_n++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    wr_n = 0; rd_n = 0; tx_n = 0;
  endtask

  task automatic send(input logic [7:0] b);
    @(posedge clk); #1;
    rx_valid = 1'b1; rx_data = b;
    do @(negedge clk); while (!rx_ready);
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  task automatic read_ptr(output logic [31:0] p);
    clear_logs();
    send(8'h4F);
    settle();
    check("R7 pointer readback byte count", 32'(tx_n), 32'd4);
    p = {tx_b[3], tx_b[2], tx_b[1], tx_b[0]};
  endtask

  task automatic t_reset();
    logic [31:0] p;
    @(negedge clk);
    check("R1 rx_ready after reset", 32'(rx_ready), 32'd1);
    check("R1 tx_valid after reset", 32'(tx_valid), 32'd0);
    check("R1 bus_valid after reset", 32'(bus_valid), 32'd0);
    check("R1 csr bank after reset", 32'(csr_regs), 32'd0);
    read_ptr(p);
    check("R1 pointer after reset", p, 32'd0);
  endtask

  task automatic t_direct_store();
    clear_logs(); bus_stall = 1;
    send(8'h26); send(8'h34); send(8'h12);
    send(8'h11); send(8'h22); send(8'h33);
    settle(); bus_stall = 0;
    check("R3 write count", 32'(wr_n), 32'd3);
    for (int i = 0; i < 3; i++) begin
      check("R3 write address", wr_addr[i], 32'h1234 + 32'(i));
      check("R3 write data", 32'(wr_data[i]), 32'h11 * 32'(i + 1));
    end
    check("R9 no rx_ready during bus request", 32'(overlap_n), 32'd0);
  endtask

  task automatic t_direct_load();
    clear_logs(); tx_stall = 1; bus_stall = 1;
    send(8'h09); send(8'h00); send(8'h80); send(8'h00);
    settle(); tx_stall = 0; bus_stall = 0;
    check("R4 read count", 32'(rd_n), 32'd2);
    check("R4 tx count", 32'(tx_n), 32'd2);
    for (int i = 0; i < 2; i++) begin
      check("R4 read address", rd_addr[i], 32'h8000 + 32'(i));
      check("R4 tx byte", 32'(tx_b[i]), 32'(mem_f(16'(32'h8000 + i))));
    end
    check("R9 no rx_ready during tx", 32'(overlap_n), 32'd0);
  endtask

  task automatic t_pointer_access();
    logic [31:0] p;
    clear_logs();
    send(8'h63); send(8'h78); send(8'h56); send(8'h34); send(8'h12);
    settle();
    check("R7 pointer store causes no bus", 32'(wr_n + rd_n), 32'd0);
    read_ptr(p);
    check("R7 full pointer store", p, 32'h12345678);
    clear_logs();
    send(8'h60); send(8'hAB);
    settle();
    read_ptr(p);
    check("R7 partial pointer store keeps upper bytes", p, 32'h123456AB);
  endtask

  task automatic t_indirect_noinc();
    logic [31:0] p;
    clear_logs();
    send(8'h63); send(8'h00); send(8'h40); send(8'h00); send(8'h00);
    clear_logs();
    send(8'h65); send(8'h05); send(8'h06);
    settle();
    check("R5 write count", 32'(wr_n), 32'd2);
    check("R5 first address", wr_addr[0], 32'h4000);
    check("R5 second address", wr_addr[1], 32'h4001);
    check("R5 second data", 32'(wr_data[1]), 32'h06);
    read_ptr(p);
    check("R5 pointer unchanged", p, 32'h4000);
  endtask

  task automatic t_post_inc();
    logic [31:0] p;
    clear_logs(); bus_stall = 1;
    send(8'h4A);
    settle(); bus_stall = 0;
    check("R6 read count", 32'(rd_n), 32'd3);
    for (int i = 0; i < 3; i++) begin
      check("R6 read address", rd_addr[i], 32'h4000 + 32'(i));
      check("R6 tx byte", 32'(tx_b[i]), 32'(mem_f(16'(32'h4000 + i))));
    end
    read_ptr(p);
    check("R6 pointer advanced", p, 32'h4003);
  endtask

  task automatic t_csr();
    clear_logs();
    send(8'hA2); send(8'h5C);
    settle();
    check("R8 status write lands", 32'(csr_regs[23:16]), 32'h5C);
    check("R8 status write no bus", 32'(wr_n + rd_n), 32'd0);
    clear_logs();
    send(8'h82);
    settle();
    check("R8 status read single byte", 32'(tx_n), 32'd1);
    check("R8 status read value", 32'(tx_b[0]), 32'h5C);
    clear_logs();
    send(8'hA6); send(8'hEE);
    settle();
    check("R8 out-of-range write ignored", 32'(csr_regs), 32'h005C0000);
    send(8'h86);
    settle();
    check("R8 out-of-range read count", 32'(tx_n), 32'd1);
    check("R8 out-of-range read zero", 32'(tx_b[0]), 32'h00);
  endtask

  task automatic t_illegal();
    clear_logs();
    send(8'hE0);
    send(8'h82);
    settle();
    check("R2 illegal opcode no bus", 32'(wr_n + rd_n), 32'd0);
    check("R2 next command runs, one byte out", 32'(tx_n), 32'd1);
    check("R2 next command value", 32'(tx_b[0]), 32'h5C);
  endtask

  task automatic t_wrap();
    clear_logs();
    send(8'h2D); send(8'hFF); send(8'hFF); send(8'h12); send(8'h00);
    send(8'h01); send(8'h02);
    settle();
    check("R10 write count", 32'(wr_n), 32'd2);
    check("R10 first address", wr_addr[0], 32'hFFFF);
    check("R10 wrapped address", wr_addr[1], 32'h0000);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_direct_store();
    t_direct_load();
    t_pointer_access();
    t_indirect_noinc();
    t_post_inc();
    t_csr();
    t_illegal();
    t_wrap();
    finish_run();
  end
endmodule